// File: doc/BRIEF.md
# Configurable Dual-Table Logic Cell

This block is one fine-grained programmable cell meant to be tiled in large numbers inside a structured-ASIC fabric. Two 3-input lookup tables share their two low address bits (`in_a`, `in_b`). A shared two-input NAND term drives the top address bit of both tables. A select input picks one table's result. That result either goes straight to the cell output or is captured in a state flip-flop, which then drives the output. Two spare inverters sit inside the cell so that routing can use them to re-drive any signal. In logic they are plain inverters, one meant to be stronger than the other.

Seventeen configuration bits set the cell's behaviour. They are loaded serially through a configuration chain while a load enable is high, and the user function is frozen during loading. Separately, the state flip-flop sits on the fabric's test scan string. When scan mode is on, it captures the scan input, and its value is always visible on the scan output, so cells can be daisy-chained.

Top module: `dlc_cell`

## Requirements
- R1: With the combinational output mode selected, `sel`=0 and `cfg_en`=0, `cell_out` equals entry `{~(nand_x & nand_y), in_b, in_a}` of table 0. Bit 2 of that index (the NAND term) is the most significant bit and `in_a` is bit 0.
- R2: Under the same conditions with `sel`=1, `cell_out` equals the entry of table 1 at the same index.
- R3: The top index bit of both tables is the NAND of `nand_x` and `nand_y`. It is 0 only when both are 1.
- R4: While `cfg_en`=1, each clock edge shifts `cfg_din` into a 17-bit chain. The first bit sent ends up as table 0 entry 7, followed by the rest of table 0 down to entry 0, then table 1 entries 7 to 0, and last the output-mode bit. `cfg_dout` shows the bit that was sent 17 shifts earlier.
- R5: When the output-mode bit is 1, `cell_out` is the flip-flop. With `cfg_en`=0 and `scan_en`=0, the flip-flop captures the selected table result at each rising edge.
- R6: With `scan_en`=1 and `cfg_en`=0, the flip-flop captures `scan_in` instead of the table result. `scan_out` always equals the flip-flop.
- R7: `rst_n`=0 at a rising edge clears the flip-flop. The configuration bits are kept.
- R8: While `cfg_en`=1, the flip-flop holds its value whatever `scan_en` is, and `cell_out` shows that held value in both output modes.
- R9: `inv_out[i]` is always the inverse of `inv_in[i]`, for the strong inverter (index 0) and the weak inverter (index 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low clear of the state flip-flop |
| in_a | input | 1 | Table address bit 0 |
| in_b | input | 1 | Table address bit 1 |
| nand_x | input | 1 | First NAND operand |
| nand_y | input | 1 | Second NAND operand |
| sel | input | 1 | Selects table 1 when high, table 0 when low |
| cfg_en | input | 1 | Configuration shift enable; freezes the user function |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output to the next cell |
| scan_en | input | 1 | Test scan mode for the state flip-flop |
| scan_in | input | 1 | Test scan data input |
| scan_out | output | 1 | State flip-flop value, feeding the next cell's scan input |
| cell_out | output | 1 | Cell result, combinational or registered |
| inv_in | input | 2 | Inputs of the spare inverters (0 strong, 1 weak) |
| inv_out | output | 2 | Outputs of the spare inverters |

## Verification
The hardest situation to reach from the ports is a configuration reload over a cell whose flip-flop holds a known non-reset value. Only that case shows at once that the output is frozen, that the old stream leaves `cfg_dout` in order, and that the new tables take effect afterwards. The stimulus first uses scan mode to set the flip-flop to 1. It then holds scan mode high while shifting in a different configuration, and it toggles the logic inputs on every cycle so that any leak of the table result into the flip-flop or the output would show. A second hard case is a reset that must clear only the flip-flop. It is reached by setting the flip-flop through scan, pulsing reset, and then reading a table entry through the registered path without reloading.

// File: rtl/dlc_pkg.sv
// Shared constants and configuration layout for the dual-table logic cell.
// Assumes a two-table cell; the packed layout fixes the serial load order.
package dlc_pkg;
    localparam int LUT_IN    = 3;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int NUM_LUTS  = 2;
    localparam int SEL_W     = (NUM_LUTS > 1) ? $clog2(NUM_LUTS) : 1;
    localparam int CFG_LEN   = NUM_LUTS * LUT_DEPTH + 1;

    typedef logic [LUT_DEPTH-1:0] lut_table_t;

    // Table 0 is the most significant field, so it is shifted in first.
    typedef struct packed {
        lut_table_t [0:NUM_LUTS-1] tables;
        logic                      reg_out;
    } cell_cfg_t;
endpackage

// File: rtl/dlc_cfg_chain.sv
// Serial configuration shift register for one cell.
// Assumes no reset: configuration survives functional reset by design.
module dlc_cfg_chain #(
    parameter int LEN = 17
) (
    input  logic           clk,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] bits,
    output logic           dout
);
    // Shift one bit toward the MSB while loading.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            bits <= {bits[LEN-2:0], din};
        end
    end

    assign dout = bits[LEN-1];
endmodule

// File: rtl/dlc_lut.sv
// Generic lookup table: returns the configured entry at the given address.
// Assumes the table width is exactly 2**N.
module dlc_lut #(
    parameter int N = 3,
    localparam int DEPTH = 1 << N
) (
    input  logic [DEPTH-1:0] tbl,
    input  logic [N-1:0]     addr,
    output logic             y
);
    // Plain indexed read of the table.
    assign y = tbl[addr];
endmodule

// File: rtl/dlc_state_flop.sv
// State flip-flop with synchronous active-low clear, load freeze and scan capture.
// Priority: clear, then freeze, then scan, then functional data.
module dlc_state_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic scan_en,
    input  logic scan_in,
    input  logic d,
    output logic q
);
    // Select the next state by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (hold) begin
            q <= q;
        end else if (scan_en) begin
            q <= scan_in;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dlc_cell.sv
// Dual-table programmable logic cell with a NAND-fed top address bit, a table
// select mux, an optional output register on the scan string, and two spare
// inverters. Assumes configuration is loaded before the cell is used.
module dlc_cell
    import dlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       nand_x,
    input  logic       nand_y,
    input  logic       sel,
    input  logic       cfg_en,
    input  logic       cfg_din,
    output logic       cfg_dout,
    input  logic       scan_en,
    input  logic       scan_in,
    output logic       scan_out,
    output logic       cell_out,
    input  logic [1:0] inv_in,
    output logic [1:0] inv_out
);
    logic [CFG_LEN-1:0]  cfg_bits;
    cell_cfg_t           cfg;
    logic                nand_out;
    logic [LUT_IN-1:0]   lut_addr;
    logic [NUM_LUTS-1:0] lut_y;
    logic                mux_out;
    logic                state_q;
    logic [SEL_W-1:0]    sel_idx;

    // Configuration storage and serial chain.
    dlc_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
        .clk      (clk),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .bits     (cfg_bits),
        .dout     (cfg_dout)
    );

    assign cfg = cell_cfg_t'(cfg_bits);

    // Shared NAND term forms the top address bit of every table.
    assign nand_out = ~(nand_x & nand_y);
    assign lut_addr = {nand_out, in_b, in_a};

    // One table per configured field.
    for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
        dlc_lut #(.N(LUT_IN)) u_lut (
            .tbl  (cfg.tables[g]),
            .addr (lut_addr),
            .y    (lut_y[g])
        );
    end

    // Table select mux.
    assign sel_idx = SEL_W'(sel);
    assign mux_out = lut_y[sel_idx];

    // State flip-flop, also a stage of the test scan string.
    dlc_state_flop u_ff (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (cfg_en),
        .scan_en (scan_en),
        .scan_in (scan_in),
        .d       (mux_out),
        .q       (state_q)
    );

    assign scan_out = state_q;

    // Output mode: registered when configured or while loading.
    always_comb begin
        if (cfg_en || cfg.reg_out) begin
            cell_out = state_q;
        end else begin
            cell_out = mux_out;
        end
    end

    // Spare re-drive inverters (index 0 strong, index 1 weak).
    for (genvar i = 0; i < 2; i++) begin : g_inv
        assign inv_out[i] = ~inv_in[i];
    end
endmodule

// File: rtl/dlc_cell_chk.sv
// Protocol checker for dlc_cell, attached by bind. Observes ports and the
// internal table-mux result; drives nothing.
module dlc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       scan_en,
    input logic       scan_in,
    input logic       scan_out,
    input logic       cell_out,
    input logic       mux_out,
    input logic [1:0] inv_in,
    input logic [1:0] inv_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> scan_out == 1'b0); // R7

    AST_SCAN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !cfg_en) |=> scan_out == $past(scan_in)); // R6

    AST_FUNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !cfg_en) |=> scan_out == $past(mux_out)); // R5

    AST_LOAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(scan_out)); // R8

    AST_LOAD_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> cell_out == scan_out); // R8

    AST_INV_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_out[0] != inv_in[0]) && (inv_out[1] != inv_in[1])); // R9
endmodule

bind dlc_cell dlc_cell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .cell_out (cell_out),
    .mux_out  (mux_out),
    .inv_in   (inv_in),
    .inv_out  (inv_out)
);

// File: tb/dlc_cell_test.sv
// Directed bench for dlc_cell: one task per scenario, each checking itself.
module dlc_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_a = 1'b0, in_b = 1'b0, nand_x = 1'b0, nand_y = 1'b0, sel = 1'b0;
    logic       cfg_en = 1'b0, cfg_din = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
    logic [1:0] inv_in = 2'b00;
    logic       cfg_dout, scan_out, cell_out;
    logic [1:0] inv_out;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] T0A = 8'hCA;
    localparam logic [7:0] T1A = 8'h35;
    localparam logic [7:0] T0B = 8'h96;
    localparam logic [7:0] T1B = 8'h1E;

    always #2 clk = ~clk;

    dlc_cell uut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .nand_x(nand_x), .nand_y(nand_y), .sel(sel),
        .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .cell_out(cell_out), .inv_in(inv_in), .inv_out(inv_out)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    function automatic logic model(input logic [7:0] t0, input logic [7:0] t1,
                                   input logic s, input logic a, input logic b,
                                   input logic x, input logic y);
        logic [2:0] ad;
        ad = {~(x & y), b, a};
        return s ? t1[ad] : t0[ad];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic [4:0] v);
        {sel, nand_y, nand_x, in_b, in_a} = v;
    endtask

    task automatic load_cfg(input logic [7:0] t0, input logic [7:0] t1, input logic ro);
        logic [16:0] s;
        s = {t0, t1, ro};
        for (int i = 16; i >= 0; i--) begin
            cfg_en  = 1'b1;
            cfg_din = s[i];
            tick();
        end
        cfg_en = 1'b0;
    endtask

    // Reset state: flip-flop cleared, held value shown while loading.
    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        tick();
        chk("R7 reset clears flop", scan_out, 1'b0);
        cfg_en = 1'b1;
        #1;
        chk("R8 load shows held flop", cell_out, 1'b0);
        cfg_en = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    // Combinational sweep of all input combinations for one table.
    task automatic t_comb(input logic s);
        load_cfg(T0A, T1A, 1'b0);
        chk("R4 chain out is first bit sent", cfg_dout, T0A[7]);
        for (int k = 0; k < 16; k++) begin
            set_in({s, 4'(k)});
            #1;
            if (s) chk("R2 table 1 entry", cell_out, model(T0A, T1A, s, in_a, in_b, nand_x, nand_y));
            else   chk("R1 table 0 entry", cell_out, model(T0A, T1A, s, in_a, in_b, nand_x, nand_y));
            @(negedge clk);
        end
        // NAND corners: only x=y=1 gives top index bit 0.
        set_in({s, 2'b11, 2'b01});
        #1;
        chk("R3 nand both high", cell_out, s ? T1A[1] : T0A[1]);
        set_in({s, 2'b10, 2'b01});
        #1;
        chk("R3 nand one low", cell_out, s ? T1A[5] : T0A[5]);
        @(negedge clk);
    endtask

    // Registered mode: flop follows the selected table on each edge.
    task automatic t_reg();
        load_cfg(T0A, T1A, 1'b1);
        for (int k = 0; k < 32; k++) begin
            logic e;
            set_in(5'((k * 7) + 3));
            e = model(T0A, T1A, sel, in_a, in_b, nand_x, nand_y);
            tick();
            chk("R5 registered output", cell_out, e);
        end
    endtask

    // Scan capture overrides the table result.
    task automatic t_scan();
        logic [7:0] pat = 8'b1011_0010;
        for (int k = 0; k < 8; k++) begin
            scan_en = 1'b1;
            scan_in = pat[k];
            set_in(5'(k * 5));
            tick();
            chk("R6 scan capture", scan_out, pat[k]);
        end
        scan_en = 1'b0;
    endtask

    // Reset clears the flop only; configuration still answers.
    task automatic t_reset_keeps_cfg();
        load_cfg(T0A, T1A, 1'b1);
        scan_en = 1'b1;
        scan_in = 1'b1;
        tick();
        scan_en = 1'b0;
        chk("R6 flop set by scan", scan_out, 1'b1);
        rst_n = 1'b0;
        tick();
        chk("R7 reset clears flop", scan_out, 1'b0);
        rst_n = 1'b1;
        set_in(5'b0_0000);   // index 4 of table 0 (T0A[4]=0)
        tick();
        chk("R7 config kept idx4", cell_out, T0A[4]);
        set_in(5'b0_0001);   // index 5 of table 0 (T0A[5]=0)
        tick();
        set_in(5'b0_0011);   // index 7 of table 0 (T0A[7]=1)
        tick();
        chk("R7 config kept idx7", cell_out, T0A[7]);
    endtask

    // Reload over a set flop: output frozen, old stream leaves in order.
    task automatic t_freeze();
        logic [16:0] olds;
        logic [16:0] news;
        load_cfg(T0A, T1A, 1'b0);
        olds = {T0A, T1A, 1'b0};
        news = {T0B, T1B, 1'b0};
        scan_en = 1'b1;
        scan_in = 1'b1;
        tick();
        for (int i = 16; i >= 0; i--) begin
            cfg_en  = 1'b1;
            cfg_din = news[i];
            scan_in = 1'b0;
            set_in(5'(i * 3));
            #1;
            chk("R8 output frozen", cell_out, 1'b1);
            tick();
            chk("R8 flop held", scan_out, 1'b1);
            if (i > 0) chk("R4 old stream order", cfg_dout, olds[i - 1]);
        end
        cfg_en  = 1'b0;
        scan_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            set_in({1'b1, 4'(k * 2 + 1)});
            #1;
            chk("R4 new table 1 loaded", cell_out,
                model(T0B, T1B, 1'b1, in_a, in_b, nand_x, nand_y));
            set_in({1'b0, 4'(k * 2)});
            #1;
            chk("R4 new table 0 loaded", cell_out,
                model(T0B, T1B, 1'b0, in_a, in_b, nand_x, nand_y));
            @(negedge clk);
        end
    endtask

    // Spare inverters.
    task automatic t_inv();
        for (int k = 0; k < 4; k++) begin
            inv_in = 2'(k);
            #1;
            chk("R9 strong inverter", inv_out[0], ~inv_in[0]);
            chk("R9 weak inverter", inv_out[1], ~inv_in[1]);
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_comb(1'b0);
        t_comb(1'b1);
        t_reg();
        t_scan();
        t_reset_keeps_cfg();
        t_freeze();
        t_inv();
        report();
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired got=running exp=done");
        report();
    end
endmodule